// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. An external dual-modulus prescaler divides the oscillator signal by either P or P+1 and reports each completed prescaler cycle as a one-clock enable pulse on `presc_pulse`. The block counts those pulses. It steers the prescaler through `mod_ctrl`, and it emits a comparison pulse `fp_pulse` once per full period. That period spans N prescaler cycles, and the first A of them use P+1. The overall division is therefore P·N + A. The synthesized frequency is that ratio multiplied by the reference input frequency and divided by the reference divider setting.

The main count N, the swallow count A and the modulus-select bit are sampled only when a period starts. Software can rewrite them at any time without producing a truncated period. The parameter `RX_PAIR` chooses the pair of base moduli available to the select bit. The block also reports the ratio the prescaler must use in the current cycle on `presc_ratio`. A power-save input holds both counters cleared and silences both outputs. When it is released, the block starts a fresh period.

Top module: `psd_feedback_div`

## Requirements
- R1: While reset is asserted, `mod_ctrl` and `fp_pulse` are 0 and `presc_ratio` equals the base modulus for a select value of 0 (32 when `RX_PAIR`=0, 64 when `RX_PAIR`=1).
- R2: On the first clock edge after reset or power-save ends, the block loads N, A and the select bit, starting a period with no `fp_pulse`. A `presc_pulse` present at that edge is not counted.
- R3: In closed loop with a prescaler that divides by `presc_ratio`, consecutive `fp_pulse` rising edges lie exactly P·N + A clocks apart, and each period contains N prescaler pulses.
- R4: `mod_ctrl` is 1 from the start of a period until A prescaler pulses of that period have been counted, and 0 for the rest of the period. With A = 0 it stays 0.
- R5: Base modulus P. With `RX_PAIR`=0, `mod_sel`=1 gives 16 and `mod_sel`=0 gives 32. With `RX_PAIR`=1, `mod_sel`=1 gives 32 and `mod_sel`=0 gives 64.
- R6: `fp_pulse` is high for exactly one clock. That clock follows the edge at which the N-th prescaler pulse of the period was counted, and the same edge starts the next period.
- R7: `swallow_a`, `main_n` and `mod_sel` are sampled only at a period start. Changing them mid-period does not alter the period in progress or the ratio on `presc_ratio`.
- R8: While `pwr_save` is 1, from the next edge on, `mod_ctrl` and `fp_pulse` are 0, `presc_ratio` shows the select-0 base modulus, and both counters stay cleared. Release starts a new period as in R2.
- R9: `presc_ratio` equals P + `mod_ctrl`. Because P is even, bit 0 of `presc_ratio` always equals `mod_ctrl`.
- R10: The supported range is N from 3 to 2047 and A from 0 to 127, with A < N. Both extremes divide correctly, and the remaining swallow count is always below the remaining main count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the prescaler pulse is an enable in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_save | input | 1 | Holds the counters cleared and the outputs quiet while 1 |
| swallow_a | input | A_W (7) | Swallow count A, sampled at each period start |
| main_n | input | N_W (11) | Main count N, sampled at each period start |
| mod_sel | input | 1 | Base modulus select, sampled at each period start |
| presc_pulse | input | 1 | One-clock pulse per completed prescaler cycle |
| mod_ctrl | output | 1 | 1 requests division by P+1 from the prescaler |
| presc_ratio | output | RATIO_W (7) | Ratio the prescaler must use now (P or P+1) |
| fp_pulse | output | 1 | One-clock comparison pulse per full period |

## Verification
The bench drives the pulse input in four ways. Back-to-back pulses on every clock with N = 3 expose any off-by-one in the wrap and reload edge. Sparse, irregular pulses show that the counters advance only on pulses and never on plain clocks. Closed-loop operation uses a behavioural prescaler that divides by `presc_ratio`, and it is the only pattern in which the fp spacing proves P·N + A end to end, both at N = 2047, A = 127 and at N = 3, A = 2. Configuration changes and power-save pulses applied mid-period separate proper sampling at the period start from sampling the inputs continuously.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Base modulus P of the dual-modulus prescaler for a channel pair and select bit.
  function automatic int unsigned base_modulus(input bit rx_pair, input bit sel_hi);
    int unsigned p;
    if (rx_pair) p = sel_hi ? 32 : 64;
    else         p = sel_hi ? 16 : 32;
    return p;
  endfunction

  // Clock count of a full period when the prescaler divides by P or P+1.
  function automatic int unsigned period_clocks(input int unsigned p,
                                                input int unsigned n,
                                                input int unsigned a);
    return p * n + a;
  endfunction

  // Largest ratio ever requested on the modulus output.
  function automatic int unsigned peak_ratio(input bit rx_pair);
    return base_modulus(rx_pair, 1'b0) + 1;
  endfunction

endpackage

// File: rtl/psd_main_ctr.sv
module psd_main_ctr #(
  parameter int N_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           pulse,
  input  logic [N_W-1:0] load_val,
  output logic [N_W-1:0] count,
  output logic           idle,
  output logic           wrap,
  output logic           reload
);

  localparam logic [N_W-1:0] LAST = N_W'(1);

  assign idle   = (count == '0);
  assign wrap   = pulse && (count == LAST);
  assign reload = idle || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (hold)   count <= '0;
    else if (reload) count <= load_val;
    else if (pulse)  count <= count - 1'b1;
  end

endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr #(
  parameter int A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           pulse,
  input  logic           reload,
  input  logic [A_W-1:0] load_val,
  output logic [A_W-1:0] count,
  output logic           active
);

  assign active = (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (hold)             count <= '0;
    else if (reload)           count <= load_val;
    else if (pulse && active)  count <= count - 1'b1;
  end

endmodule

// File: rtl/psd_modulus_sel.sv
module psd_modulus_sel #(
  parameter bit RX_PAIR = 1'b0,
  parameter int RATIO_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               reload,
  input  logic               sel_in,
  input  logic               swallow_active,
  output logic [RATIO_W-1:0] ratio
);

  localparam int unsigned P_SEL_HI = psd_pkg::base_modulus(RX_PAIR, 1'b1);
  localparam int unsigned P_SEL_LO = psd_pkg::base_modulus(RX_PAIR, 1'b0);
  localparam int unsigned P_PEAK   = psd_pkg::peak_ratio(RX_PAIR);

  logic               sel_q;
  logic [RATIO_W-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (hold)   sel_q <= 1'b0;
    else if (reload) sel_q <= sel_in;
  end

  generate
    if (P_PEAK < (1 << RATIO_W)) begin : g_fit
      assign base = sel_q ? RATIO_W'(P_SEL_HI) : RATIO_W'(P_SEL_LO);
    end else begin : g_sat
      assign base = {RATIO_W{1'b1}} - 1'b1;
    end
  endgenerate

  assign ratio = base + {{(RATIO_W-1){1'b0}}, swallow_active};

endmodule

// File: rtl/psd_feedback_div.sv
module psd_feedback_div #(
  parameter int A_W     = 7,
  parameter int N_W     = 11,
  parameter bit RX_PAIR = 1'b0,
  parameter int RATIO_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_save,
  input  logic [A_W-1:0]     swallow_a,
  input  logic [N_W-1:0]     main_n,
  input  logic               mod_sel,
  input  logic               presc_pulse,
  output logic               mod_ctrl,
  output logic [RATIO_W-1:0] presc_ratio,
  output logic               fp_pulse
);

  // Named internal events for the checker
  logic [N_W-1:0] main_count;
  logic [A_W-1:0] swallow_count;
  logic           main_idle;
  logic           main_wrap;
  logic           period_start;
  logic           swallow_active;
  logic           fp_q;

  psd_main_ctr #(.N_W(N_W)) main_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (pwr_save),
    .pulse    (presc_pulse),
    .load_val (main_n),
    .count    (main_count),
    .idle     (main_idle),
    .wrap     (main_wrap),
    .reload   (period_start)
  );

  psd_swallow_ctr #(.A_W(A_W)) swallow_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (pwr_save),
    .pulse    (presc_pulse),
    .reload   (period_start),
    .load_val (swallow_a),
    .count    (swallow_count),
    .active   (swallow_active)
  );

  psd_modulus_sel #(.RX_PAIR(RX_PAIR), .RATIO_W(RATIO_W)) modsel_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .hold           (pwr_save),
    .reload         (period_start),
    .sel_in         (mod_sel),
    .swallow_active (swallow_active),
    .ratio          (presc_ratio)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fp_q <= 1'b0;
    else        fp_q <= main_wrap && !pwr_save;
  end

  assign mod_ctrl = swallow_active;
  assign fp_pulse = fp_q;

endmodule

// File: rtl/psd_feedback_div_chk.sv
module psd_feedback_div_chk #(
  parameter int A_W = 7,
  parameter int N_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pwr_save,
  input logic           presc_pulse,
  input logic           mod_ctrl,
  input logic           fp_pulse,
  input logic           ratio_lsb,
  input logic           main_idle,
  input logic [N_W-1:0] m_cnt,
  input logic [A_W-1:0] s_cnt
);

  logic [N_W-1:0] s_ext;
  assign s_ext = N_W'(s_cnt);

  p_fp_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fp_pulse |-> $past(presc_pulse));

  p_fp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fp_pulse |=> !fp_pulse);

  p_pwrsave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_save |=> (main_idle && !mod_ctrl && !fp_pulse));

  p_load_no_fp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (main_idle && !pwr_save) |=> (!fp_pulse && !main_idle));

  p_mod_moves_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_ctrl) |-> ($past(presc_pulse) || $past(main_idle) || $past(pwr_save)));

  p_swallow_below_main_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !main_idle |-> (s_ext < m_cnt));

  p_ratio_odd_when_swallow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_lsb == mod_ctrl);

endmodule

bind psd_feedback_div psd_feedback_div_chk #(.A_W(A_W), .N_W(N_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_save    (pwr_save),
  .presc_pulse (presc_pulse),
  .mod_ctrl    (mod_ctrl),
  .fp_pulse    (fp_pulse),
  .ratio_lsb   (presc_ratio[0]),
  .main_idle   (main_idle),
  .m_cnt       (main_count),
  .s_cnt       (swallow_count)
);

// File: tb/psd_feedback_div_tb_top.sv
`timescale 1ns/1ps
module psd_feedback_div_tb_top;

  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_save = 1'b0;
  logic [6:0] a_in = 7'd3;
  logic [10:0] n_in = 11'd10;
  logic       sel_in = 1'b1;
  logic       closed_loop = 1'b0;
  logic       man_pulse = 1'b0;
  logic       pm_pulse = 1'b0;
  logic       presc_pulse;
  logic       mod_tx, fp_tx, mod_rx, fp_rx;
  logic [6:0] ratio_tx, ratio_rx;

  always #2 clk = ~clk;

  assign presc_pulse = closed_loop ? pm_pulse : man_pulse;

  psd_feedback_div #(.RX_PAIR(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_save(pwr_save), .swallow_a(a_in), .main_n(n_in),
    .mod_sel(sel_in), .presc_pulse(presc_pulse), .mod_ctrl(mod_tx),
    .presc_ratio(ratio_tx), .fp_pulse(fp_tx));

  psd_feedback_div #(.RX_PAIR(1'b1)) dut_rx (
    .clk(clk), .rst_n(rst_n), .pwr_save(pwr_save), .swallow_a(a_in), .main_n(n_in),
    .mod_sel(sel_in), .presc_pulse(presc_pulse), .mod_ctrl(mod_rx),
    .presc_ratio(ratio_rx), .fp_pulse(fp_rx));

  // Base modulus from R5, written as a doubling rule
  function automatic int ref_p(input bit rx, input bit sel);
    int p;
    p = rx ? 32 : 16;
    if (!sel) p = p * 2;
    return p;
  endfunction

  // Behavioural reference: pulses counted since the period began
  bit m_armed = 0;
  int m_pulses = 0, m_a = 0, m_n = 0;
  bit m_sel = 0, m_fp = 0;
  int m_last_len = 0;

  always @(posedge clk) begin
    if (!rst_n || pwr_save) begin
      m_armed = 0; m_pulses = 0; m_a = 0; m_n = 0; m_sel = 0; m_fp = 0;
    end else if (!m_armed) begin
      m_armed = 1; m_a = int'(a_in); m_n = int'(n_in); m_sel = sel_in;
      m_pulses = 0; m_fp = 0;
    end else if (presc_pulse) begin
      if (m_pulses + 1 == m_n) begin
        m_last_len = ref_p(0, m_sel) * m_n + m_a;
        m_fp = 1;
        m_a = int'(a_in); m_n = int'(n_in); m_sel = sel_in; m_pulses = 0;
      end else begin
        m_pulses = m_pulses + 1; m_fp = 0;
      end
    end else begin
      m_fp = 0;
    end
  end

  // Behavioural prescaler: one pulse per presc_ratio clocks
  int pcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      pcnt = 0; pm_pulse = 1'b0;
    end else if (pcnt + 1 >= int'(ratio_tx)) begin
      pcnt = 0; pm_pulse = 1'b1;
    end else begin
      pcnt = pcnt + 1; pm_pulse = 1'b0;
    end
  end

  int checks = 0, failures = 0, cyc = 0;
  int last_fp_cyc = 0;
  bit fp_ref_valid = 0;
  int man_mode = 0;   // 0 none, 1 every clock, 2 irregular
  int fp_seen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic step();
    bit exp_mod;
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin
      failures++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      finish_run();
    end
    if (rst_n) begin
      exp_mod = m_armed && (m_pulses < m_a);
      check(mod_tx == exp_mod, "R4", "mod_ctrl", int'(mod_tx), int'(exp_mod));
      check(fp_tx == m_fp, "R6", "fp_pulse", int'(fp_tx), int'(m_fp));
      check(int'(ratio_tx) == ref_p(0, m_sel) + int'(exp_mod), "R9", "ratio tx",
            int'(ratio_tx), ref_p(0, m_sel) + int'(exp_mod));
      check(int'(ratio_rx) == ref_p(1, m_sel) + int'(exp_mod), "R5", "ratio rx",
            int'(ratio_rx), ref_p(1, m_sel) + int'(exp_mod));
      check(fp_rx == m_fp, "R6", "fp_pulse rx", int'(fp_rx), int'(m_fp));
    end
    if (!rst_n || pwr_save) fp_ref_valid = 0;
    if (fp_tx) begin
      fp_seen++;
      if (fp_ref_valid && closed_loop)
        check(cyc - last_fp_cyc == m_last_len, "R3 R7", "fp spacing",
              cyc - last_fp_cyc, m_last_len);
      last_fp_cyc = cyc;
      fp_ref_valid = closed_loop;
    end
    case (man_mode)
      1:       man_pulse = 1'b1;
      2:       man_pulse = (cyc % 3) != 0;
      default: man_pulse = 1'b0;
    endcase
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic wait_fp(input int k);
    int target;
    target = fp_seen + k;
    while (fp_seen < target) step();
  endtask

  task automatic set_cfg(input bit s, input int n, input int a);
    sel_in = s; n_in = 11'(n); a_in = 7'(a);
  endtask

  initial begin
    bit any_mod;
    // R1: reset state
    run(3);
    check(mod_tx == 1'b0, "R1", "mod_ctrl in reset", int'(mod_tx), 0);
    check(fp_tx == 1'b0, "R1", "fp_pulse in reset", int'(fp_tx), 0);
    check(int'(ratio_tx) == 32, "R1", "tx ratio in reset", int'(ratio_tx), 32);
    check(int'(ratio_rx) == 64, "R1", "rx ratio in reset", int'(ratio_rx), 64);

    // R2: release with a pulse at the load edge, which must not count
    rst_n = 1'b1; man_pulse = 1'b1;
    step();
    check(mod_tx == 1'b1, "R2", "mod_ctrl after load", int'(mod_tx), 1);
    check(fp_tx == 1'b0, "R2", "no fp at load", int'(fp_tx), 0);
    check(int'(ratio_tx) == 17, "R2", "ratio after load", int'(ratio_tx), 17);

    // Sparse irregular pulses, then back-to-back pulses at N=3 (R4 R6)
    man_mode = 2;
    run(60);
    set_cfg(1'b0, 3, 2);
    man_mode = 1;
    wait_fp(5);
    // A = 0: modulus control never raised (R4)
    set_cfg(1'b1, 4, 0);
    man_mode = 2;
    wait_fp(2);
    any_mod = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (mod_tx) any_mod = 1;
    end
    check(any_mod == 0, "R4", "mod_ctrl with A=0", int'(any_mod), 0);

    // Closed loop (R3)
    man_mode = 0;
    set_cfg(1'b1, 10, 3);
    closed_loop = 1'b1; fp_ref_valid = 0;
    wait_fp(4);

    // Mid-period change (R7)
    run(40);
    set_cfg(1'b0, 5, 1);
    run(5);
    check(int'(ratio_tx) <= 17, "R7", "ratio keeps old select", int'(ratio_tx), 17);
    wait_fp(3);

    // Power save mid-period (R8)
    run(30);
    pwr_save = 1'b1;
    run(3);
    check(mod_tx == 1'b0, "R8", "mod_ctrl in power save", int'(mod_tx), 0);
    check(fp_tx == 1'b0, "R8", "fp in power save", int'(fp_tx), 0);
    check(int'(ratio_tx) == 32, "R8", "ratio in power save", int'(ratio_tx), 32);
    pwr_save = 1'b0;
    step();
    check(mod_tx == 1'b1, "R8", "restart loads A=1", int'(mod_tx), 1);
    wait_fp(3);

    // Range extremes (R10)
    set_cfg(1'b1, 2047, 127);
    wait_fp(2);
    check(m_last_len == 32879, "R10", "max period length", m_last_len, 32879);
    set_cfg(1'b0, 3, 2);
    wait_fp(3);
    check(m_last_len == 98, "R10", "min period length", m_last_len, 98);

    finish_run();
  end

endmodule